// File: doc/BRIEF.md
# Mode-Aware Eight-Pin GPIO Port

This block is an eight-pin general-purpose port with a small register bank on a simple peripheral bus. Software chooses per pin whether it drives or listens, sets the value driven, turns on a weak pull-up for listening pins and can make driving pins open-drain. A pin-state register reads back the live port: the value being driven for pins that drive, and the synchronized pad input for the rest.

When the chip runs in one of its external-bus modes, a four-bit address-enable field from the bus controller takes pins away from software. Each enable bit claims one pair of pins, and those pins then drive external address bits no matter what the direction register holds. In single-chip mode, and in every other mode code, the override is off and all eight pins are plain GPIO.

Two standby inputs set the low-power behaviour. Hardware standby clears every register and floats every pin at once. Software standby freezes the registers and blocks all bus writes. The pins that carry address bits either keep driving the last address seen before standby or float, as an output-hold input selects. The register bus is a plain single-cycle strobe with no back-pressure. A write takes effect at the clock edge where select and write are both high. Read data is combinational for as long as select is high and write is low.

Top module: `gpio8_mode_port`

## Requirements
- R1: After reset the data, pull-up and open-drain registers read 0x00, and the pin output-enable, output value, pull-up and open-drain outputs are all 0x00.
- R2: The direction register at offset 0xFE3A can only be written; reading that offset returns 0x00.
- R3: A direction bit of 1 makes its pin drive (pin_oe bit 1, pin_out bit = data register bit); a 0 makes it an input (pin_oe bit 0).
- R4: The data (0xFF0A), pull-up (0xFE41) and open-drain (0xFE48) registers read back the last value written.
- R5: When opmode is 4, 5 or 6, address-enable bit n makes pins 2n and 2n+1 drive ext_addr bits 2n and 2n+1 with pin_oe 1, whatever the direction bits hold; pull-up and open-drain are then off for those pins.
- R6: When opmode is 7, or any code below 4, address-enable has no effect and every pin follows the direction register.
- R7: pin_pu bit is 1 only when the pin is an input (direction 0, no address override) and its pull-up bit is 1.
- R8: A driving GPIO pin with its open-drain bit set drives 0 (pin_out 0, pin_oe 1) when its data bit is 0 and releases the pin (pin_oe 0) when its data bit is 1; pin_od reports the pins in this state.
- R9: Reading the pin-state offset 0xFFBA returns the data bit for driving GPIO pins and, for all other pins, pin_in delayed through two clock edges. A write to 0xFFBA changes nothing.
- R10: While hw_stby is high all pin outputs are 0x00, and every register is cleared to 0x00.
- R11: While sw_stby is high the registers keep their contents and bus writes are ignored.
- R12: In software standby, address-override pins drive the ext_addr value captured at the last edge before standby when out_hold is 1, and float (pin_oe 0) when out_hold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: clears registers, floats pins |
| sw_stby | input | 1 | Software standby: freezes registers |
| out_hold | input | 1 | In software standby, 1 keeps address pins driving |
| opmode | input | 3 | Operating mode; 4 to 6 enable the address override |
| addr_en | input | 4 | Address-enable field, one bit per pin pair |
| ext_addr | input | 8 | External address bits from the bus controller |
| pin_in | input | 8 | Pad input values (asynchronous) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register offset (lower 16 address bits) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0x00 when not reading |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pull-up enable |
| pin_od | output | 8 | Per-pin open-drain active |

## Verification
The pin mux is run with a mixed direction pattern (0x0F) and the data value 0xA5, which is not symmetric. This shows whether driving and listening pins are swapped, and whether output values come from the data register or from the pads. The same direction setting is then run under address-enable 0101 in modes 7, 3 and 5. This shows that the override claims whole pin pairs (mask 0x33) and only in external-bus modes. Because 0x33 cuts across the direction mask, it also shows that the override wins over the direction bits. Open-drain, pull-up and the pin-state readback are tried on the same pattern, so a pin taken from the wrong source gives a different byte. The standby runs change ext_addr after entry, which separates a held address from a live one.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

  localparam int ADDR_W = 16;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 16'hFE3A;
  localparam logic [ADDR_W-1:0] OFS_DATA = 16'hFF0A;
  localparam logic [ADDR_W-1:0] OFS_PINS = 16'hFFBA;
  localparam logic [ADDR_W-1:0] OFS_PULL = 16'hFE41;
  localparam logic [ADDR_W-1:0] OFS_ODRN = 16'hFE48;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_DIR,
    RSEL_DATA,
    RSEL_PINS,
    RSEL_PULL,
    RSEL_ODRN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DIR:  return RSEL_DIR;
      OFS_DATA: return RSEL_DATA;
      OFS_PINS: return RSEL_PINS;
      OFS_PULL: return RSEL_PULL;
      OFS_ODRN: return RSEL_ODRN;
      default:  return RSEL_NONE;
    endcase
  endfunction

  function automatic logic is_ext_bus_mode(input logic [2:0] m);
    return (m == 3'd4) || (m == 3'd5) || (m == 3'd6);
  endfunction

endpackage

// File: rtl/gpio8_regfile.sv
module gpio8_regfile
  import gpio8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      pull_q,
  output logic [W-1:0]      odrn_q
);

  reg_sel_e wsel;
  logic     wr_ok;

  assign wsel  = decode_ofs(bus_addr);
  assign wr_ok = bus_sel && bus_wr && !sw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
      pull_q <= '0;
      odrn_q <= '0;
    end else if (hw_stby) begin
      dir_q  <= '0;
      data_q <= '0;
      pull_q <= '0;
      odrn_q <= '0;
    end else if (wr_ok) begin
      case (wsel)
        RSEL_DIR:  dir_q  <= bus_wdata;
        RSEL_DATA: data_q <= bus_wdata;
        RSEL_PULL: pull_q <= bus_wdata;
        RSEL_ODRN: odrn_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  AST_HWSTBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == '0) && (data_q == '0) && (pull_q == '0) && (odrn_q == '0)); // R10

  AST_SWSTBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> $stable(dir_q) && $stable(data_q) && $stable(pull_q) && $stable(odrn_q)); // R11

endmodule

// File: rtl/gpio8_insync.sv
module gpio8_insync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio8_pinmux.sv
module gpio8_pinmux #(
  parameter int W    = 8,
  parameter int AE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_stby,
  input  logic            sw_stby,
  input  logic            out_hold,
  input  logic            ext_bus,
  input  logic [AE_W-1:0] addr_en,
  input  logic [W-1:0]    ext_addr,
  input  logic [W-1:0]    addr_hold,
  input  logic [W-1:0]    dir_q,
  input  logic [W-1:0]    data_q,
  input  logic [W-1:0]    pull_q,
  input  logic [W-1:0]    odrn_q,
  output logic [W-1:0]    pin_out,
  output logic [W-1:0]    pin_oe,
  output logic [W-1:0]    pin_pu,
  output logic [W-1:0]    pin_od,
  output logic [W-1:0]    gpio_drv
);

  localparam int PER = W / AE_W;

  logic [W-1:0] ovr;
  logic [W-1:0] od_en;

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam int AE_IDX = i / PER;
    assign ovr[i]      = ext_bus & addr_en[AE_IDX];
    assign od_en[i]    = ~ovr[i] & dir_q[i] & odrn_q[i];
    assign gpio_drv[i] = ~ovr[i] & dir_q[i];
    assign pin_out[i]  = hw_stby ? 1'b0 :
                         ovr[i]  ? (sw_stby ? addr_hold[i] : ext_addr[i]) :
                         (od_en[i] ? 1'b0 : data_q[i]);
    assign pin_oe[i]   = hw_stby ? 1'b0 :
                         ovr[i]  ? (~sw_stby | out_hold) :
                         (dir_q[i] & ~(od_en[i] & data_q[i]));
    assign pin_pu[i]   = ~hw_stby & ~ovr[i] & ~dir_q[i] & pull_q[i];
    assign pin_od[i]   = ~hw_stby & od_en[i];
  end

  AST_PU_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pu & pin_oe) == '0); // R7

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_od & pin_oe & pin_out) == '0); // R8

endmodule

// File: rtl/gpio8_mode_port.sv
module gpio8_mode_port
  import gpio8_pkg::*;
#(
  parameter int W           = 8,
  parameter int AE_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              out_hold,
  input  logic [2:0]        opmode,
  input  logic [AE_W-1:0]   addr_en,
  input  logic [W-1:0]      ext_addr,
  input  logic [W-1:0]      pin_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_pu,
  output logic [W-1:0]      pin_od
);

  localparam int PER = W / AE_W;

  logic [W-1:0] dir_q, data_q, pull_q, odrn_q;
  logic [W-1:0] pin_sync, gpio_drv, addr_hold;
  logic         ext_bus;
  reg_sel_e     rsel;

  assign ext_bus = is_ext_bus_mode(opmode);

  gpio8_regfile #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q), .odrn_q(odrn_q)
  );

  gpio8_insync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_hold <= '0;
    else if (!sw_stby) addr_hold <= ext_addr;
  end

  gpio8_pinmux #(.W(W), .AE_W(AE_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .out_hold(out_hold), .ext_bus(ext_bus), .addr_en(addr_en),
    .ext_addr(ext_addr), .addr_hold(addr_hold),
    .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q), .odrn_q(odrn_q),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_od(pin_od),
    .gpio_drv(gpio_drv)
  );

  assign rsel = decode_ofs(bus_addr);

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (rsel)
        RSEL_DATA: bus_rdata = data_q;
        RSEL_PINS: bus_rdata = (data_q & gpio_drv) | (pin_sync & ~gpio_drv);
        RSEL_PULL: bus_rdata = pull_q;
        RSEL_ODRN: bus_rdata = odrn_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  logic [W-1:0] ovr_mask;
  always_comb begin
    for (int i = 0; i < W; i++) ovr_mask[i] = ext_bus && addr_en[i/PER];
  end

  AST_DIR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFS_DIR) |-> bus_rdata == '0); // R2

  AST_OVR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_stby && !sw_stby) |-> (pin_oe & ovr_mask) == ovr_mask); // R5

  AST_NO_OVR_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_bus) |-> (pin_oe & ~dir_q) == '0); // R6

  AST_HWSTBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> (pin_oe == '0) && (pin_pu == '0) && (pin_od == '0)); // R10

  AST_ADDR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !out_hold && !hw_stby) |-> (pin_oe & ovr_mask) == '0); // R12

endmodule

// File: tb/tb_gpio8_mode_port.sv
`timescale 1ns/1ps
module tb_gpio8_mode_port;

  localparam logic [15:0] A_DIR = 16'hFE3A, A_DATA = 16'hFF0A, A_PINS = 16'hFFBA,
                          A_PULL = 16'hFE41, A_ODRN = 16'hFE48;
  localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_PU = 3, K_OD = 4;

  logic clk = 0, rst_n = 0, hw_stby = 0, sw_stby = 0, out_hold = 0;
  logic [2:0]  opmode = 3'd7;
  logic [3:0]  addr_en = '0;
  logic [7:0]  ext_addr = '0, pin_in = '0, bus_wdata = '0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_rdata, pin_out, pin_oe, pin_pu, pin_od;

  always #2.5 clk = ~clk;

  gpio8_mode_port dut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby), .out_hold(out_hold),
    .opmode(opmode), .addr_en(addr_en), .ext_addr(ext_addr), .pin_in(pin_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu), .pin_od(pin_od)
  );

  typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [7:0] pick(input int k);
    case (k)
      K_RD:  return bus_rdata;
      K_OE:  return pin_oe;
      K_OUT: return pin_out;
      K_PU:  return pin_pu;
      default: return pin_od;
    endcase
  endfunction

  // monitor: compares queued expectations 1 ns after the negedge they were pushed on
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = pick(it.kind);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int k, input logic [7:0] e, input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] e, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    expect_val(K_RD, e, tag);
    @(negedge clk);
    bus_sel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    // R1 reset state
    rd_chk(A_DATA, 8'h00, "R1 data");
    rd_chk(A_PULL, 8'h00, "R1 pull");
    rd_chk(A_ODRN, 8'h00, "R1 odrn");
    expect_val(K_OE, 8'h00, "R1 oe"); expect_val(K_PU, 8'h00, "R1 pu");
    expect_val(K_OD, 8'h00, "R1 od"); expect_val(K_OUT, 8'h00, "R1 out"); step();

    bus_write(A_DIR, 8'h0F);
    bus_write(A_DATA, 8'hA5);
    expect_val(K_OE, 8'h0F, "R3 oe"); expect_val(K_OUT, 8'hA5, "R3 out"); step();
    rd_chk(A_DIR, 8'h00, "R2 dir read");
    rd_chk(A_DATA, 8'hA5, "R4 data");

    bus_write(A_PULL, 8'hFF);
    expect_val(K_PU, 8'hF0, "R7 pu"); step();
    rd_chk(A_PULL, 8'hFF, "R4 pull");

    bus_write(A_ODRN, 8'h03);
    expect_val(K_OE, 8'h0E, "R8 oe"); expect_val(K_OUT, 8'hA4, "R8 out");
    expect_val(K_OD, 8'h03, "R8 od"); step();
    rd_chk(A_ODRN, 8'h03, "R4 odrn");
    bus_write(A_ODRN, 8'h00);

    // R9 pin-state readback through two sync stages
    pin_in = 8'h3C;
    rd_chk(A_PINS, 8'h05, "R9 pins 0 edges");
    rd_chk(A_PINS, 8'h05, "R9 pins 1 edge");
    rd_chk(A_PINS, 8'h35, "R9 pins 2 edges");
    bus_write(A_PINS, 8'hFF);
    rd_chk(A_DATA, 8'hA5, "R9 write ignored data");
    rd_chk(A_PINS, 8'h35, "R9 write ignored pins");

    // R6 no override outside external-bus modes
    addr_en = 4'b0101; ext_addr = 8'h5A; opmode = 3'd7;
    expect_val(K_OE, 8'h0F, "R6 mode7 oe"); expect_val(K_OUT, 8'hA5, "R6 mode7 out"); step();
    opmode = 3'd3;
    expect_val(K_OE, 8'h0F, "R6 mode3 oe"); step();

    // R5 override in mode 5 on pairs 0 and 2 (mask 0x33)
    opmode = 3'd5;
    expect_val(K_OE, 8'h3F, "R5 oe"); expect_val(K_OUT, 8'h96, "R5 out");
    expect_val(K_PU, 8'hC0, "R5 pu"); step();

    // R12/R11 software standby
    sw_stby = 1; out_hold = 1; ext_addr = 8'hFF;
    expect_val(K_OUT, 8'h96, "R12 hold out"); expect_val(K_OE, 8'h3F, "R12 hold oe"); step();
    bus_write(A_DATA, 8'h00);
    out_hold = 0;
    expect_val(K_OE, 8'h0C, "R12 hiz oe"); step();
    sw_stby = 0;
    rd_chk(A_DATA, 8'hA5, "R11 write ignored");
    expect_val(K_OE, 8'h3F, "R11 dir kept"); expect_val(K_OUT, 8'hB7, "R5 live addr"); step();

    // R10 hardware standby
    hw_stby = 1;
    expect_val(K_OE, 8'h00, "R10 oe"); expect_val(K_PU, 8'h00, "R10 pu");
    expect_val(K_OUT, 8'h00, "R10 out"); step();
    step();
    hw_stby = 0;
    rd_chk(A_DATA, 8'h00, "R10 data cleared");
    rd_chk(A_PULL, 8'h00, "R10 pull cleared");
    opmode = 3'd7;
    expect_val(K_OE, 8'h00, "R10 dir cleared"); step();
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule